// File: doc/BRIEF.md
# Mapped-Window Configuration Access Decoder

This block sits on a host I/O port bus and turns accesses to a 4 KB I/O window into configuration requests. Two byte-wide control ports set it up. The first is the enable/function port. When its upper nibble holds all ones, the window opens, and bits 3:1 of that port select the function number. The second is the forward port, which holds the target bus number.

While the window is open, the decoder claims every access to it. The device number and the register offset come from the I/O address of the access. The decoder then raises one configuration request and holds it until the target answers. After that it acknowledges the host with the returned data, masked to the lanes that the host accessed.

A host that has just written zero to both control ports reads zero back from both. Writing zero to the enable port closes the window. Once the window is closed, accesses to it fall through to other decoders on the bus.

Top module: `cfg2_window_decoder`

## Requirements
- R1: After reset both control ports read zero, the window is closed, and io_ack_o and cfg_req_o are low.
- R2: The enable port is the byte at I/O 0xCF8, on data lane 0 (bits 7:0). A write to it stores all 8 bits, and a read returns the stored value on that lane. A dword read at 0xCF8 returns the enable port in bits 7:0, the forward port in bits 23:16, and zero elsewhere.
- R3: The forward port is the byte at I/O 0xCFA, on data lane 2 (bits 23:16). It reads back what was written to it. After zero is written to both ports, both read zero.
- R4: The window is open only while bits 7:4 of the enable port equal 0xF. Any other upper nibble, for example 0xE2, leaves it closed. Writing 0x00 closes it.
- R5: No access is claimed, acknowledged or forwarded if it falls outside 0xC000–0xCFFF and outside the dword at 0xCF8, or if it targets the window while the window is closed.
- R6: A claimed window access raises cfg_req_o one cycle after the request. The request carries the following fields:
  - bus = forward port
  - function = enable port bits 3:1
  - device = address bits 11:8
  - dword index = address bits 7:2
  - direction and write data from the host, with write data zeroed on lanes that are not enabled
- R7: Size code 0 is a byte access, 1 a word and 2 a dword. A byte access enables lane addr[1:0]. A word access enables lanes 1:0 when addr[1] is 0 and lanes 3:2 when it is 1. A dword access enables all four lanes.
- R8: cfg_req_o and its fields stay steady until cfg_ack_i is high at a clock edge. io_ack_o goes high in the following cycle and cfg_req_o drops.
- R9: Read data of a present target appears on the enabled lanes, and the other lanes read zero. An absent target (cfg_present_i low) reads all ones on the enabled lanes. A write acknowledges with zero data.
- R10: An access to the control ports is acknowledged one cycle after the request. io_ack_o is always a single-cycle pulse.
- R11: A request that arrives while a transaction is in progress is not claimed and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | Host I/O access strobe, one cycle |
| io_we_i | input | 1 | Host access is a write |
| io_addr_i | input | 16 | Host I/O byte address |
| io_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata_i | input | 32 | Host write data, lane aligned |
| io_claim_o | output | 1 | Access decoded by this block (same cycle) |
| io_ack_o | output | 1 | Access complete, one-cycle pulse |
| io_rdata_o | output | 32 | Read data, valid with io_ack_o |
| cfg_req_o | output | 1 | Configuration request pending |
| cfg_we_o | output | 1 | Configuration write |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_dev_o | output | 4 | Target device number |
| cfg_func_o | output | 3 | Target function number |
| cfg_dword_o | output | 6 | Dword index in the 256-byte space |
| cfg_be_o | output | 4 | Byte lane enables |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_ack_i | input | 1 | Target completes the request |
| cfg_present_i | input | 1 | Target device responded |
| cfg_rdata_i | input | 32 | Target read data |

## Verification
The window path is exercised with byte, word and dword accesses at every low-address alignment, which separates the lane-enable rules from each other. Devices 7, 3 and 15 together with distinct dword offsets show that the device and offset fields come from the address and are not shifted. Reads of present and absent targets, and writes, tell apart the three ways the returned data is formed. Enable values with a wrong upper nibble, addresses just outside the window, and a request made while the decoder is busy show that only the intended accesses are claimed.

// File: rtl/cfg2_pkg.sv
package cfg2_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NL = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } io_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_ACK  = 2'd2
  } xact_state_e;

  function automatic logic [NL-1:0] lanes_for(input logic [1:0] size, input logic [1:0] a);
    logic [NL-1:0] m;
    case (size)
      SZ_BYTE: m = NL'(1) << a;
      SZ_WORD: m = a[1] ? NL'(4'b1100) : NL'(4'b0011);
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [NL-1:0] be);
    logic [DW-1:0] m;
    for (int l = 0; l < NL; l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg2_addr_decode.sv
module cfg2_addr_decode
  import cfg2_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter logic [15:0] WIN_BASE = 16'hC000,
  parameter logic [15:0] EN_PORT  = 16'hCF8,
  parameter logic [15:0] FWD_PORT = 16'hCFA
) (
  input  logic             req_i,
  input  logic             idle_i,
  input  logic             active_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic [1:0]       size_i,
  output logic [NL-1:0]    be_o,
  output logic             hit_reg_o,
  output logic             hit_win_o,
  output logic             claim_o
);
  localparam int unsigned WIN_AW   = 12;
  localparam int unsigned EN_LANE  = int'(EN_PORT[1:0]);
  localparam int unsigned FWD_LANE = int'(FWD_PORT[1:0]);
  localparam logic [IO_AW-1:0] EN_A  = IO_AW'(EN_PORT);
  localparam logic [IO_AW-1:0] WIN_A = IO_AW'(WIN_BASE);

  always_comb begin
    be_o      = lanes_for(size_i, addr_i[1:0]);
    hit_reg_o = (addr_i[IO_AW-1:2] == EN_A[IO_AW-1:2]) && (be_o[EN_LANE] || be_o[FWD_LANE]);
    hit_win_o = (addr_i[IO_AW-1:WIN_AW] == WIN_A[IO_AW-1:WIN_AW]);
    claim_o   = req_i && idle_i && (hit_reg_o || (hit_win_o && active_i));
  end
endmodule

// File: rtl/cfg2_ctrl_regs.sv
module cfg2_ctrl_regs
  import cfg2_pkg::*;
#(
  parameter logic [15:0] EN_PORT  = 16'hCF8,
  parameter logic [15:0] FWD_PORT = 16'hCFA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NL-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [7:0]    en_q_o,
  output logic [7:0]    fwd_q_o,
  output logic          active_o,
  output logic [2:0]    func_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned EN_LANE  = int'(EN_PORT[1:0]);
  localparam int unsigned FWD_LANE = int'(FWD_PORT[1:0]);

  logic [7:0] en_q, fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      fwd_q <= '0;
    end else if (wr_i) begin
      if (be_i[EN_LANE])  en_q  <= wdata_i[EN_LANE*8 +: 8];
      if (be_i[FWD_LANE]) fwd_q <= wdata_i[FWD_LANE*8 +: 8];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[EN_LANE*8 +: 8]  = en_q;
    rdata_o[FWD_LANE*8 +: 8] = fwd_q;
    rdata_o = rdata_o & lane_mask(be_i);
  end

  assign active_o = (en_q[7:4] == 4'hF);
  assign func_o   = en_q[3:1];
  assign en_q_o   = en_q;
  assign fwd_q_o  = fwd_q;
endmodule

// File: rtl/cfg2_xact_fsm.sv
module cfg2_xact_fsm
  import cfg2_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic          hit_reg_i,
  input  logic          we_i,
  input  logic [11:0]   win_off_i,
  input  logic [NL-1:0] be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [7:0]    bus_i,
  input  logic [2:0]    func_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          idle_o,
  output logic          io_ack_o,
  output logic [DW-1:0] io_rdata_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [7:0]    cfg_bus_o,
  output logic [3:0]    cfg_dev_o,
  output logic [2:0]    cfg_func_o,
  output logic [5:0]    cfg_dword_o,
  output logic [NL-1:0] cfg_be_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ack_i,
  input  logic          cfg_present_i,
  input  logic [DW-1:0] cfg_rdata_i
);
  xact_state_e state_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      cfg_we_o    <= 1'b0;
      cfg_bus_o   <= '0;
      cfg_dev_o   <= '0;
      cfg_func_o  <= '0;
      cfg_dword_o <= '0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (claim_i) begin
          if (hit_reg_i) begin
            state_q <= ST_ACK;
            rdata_q <= we_i ? '0 : reg_rdata_i;
          end else begin
            state_q     <= ST_CFG;
            cfg_we_o    <= we_i;
            cfg_bus_o   <= bus_i;
            cfg_func_o  <= func_i;
            cfg_dev_o   <= win_off_i[11:8];
            cfg_dword_o <= win_off_i[7:2];
            cfg_be_o    <= be_i;
            cfg_wdata_o <= wdata_i & lane_mask(be_i);
          end
        end
        ST_CFG: if (cfg_ack_i) begin
          state_q <= ST_ACK;
          // absent target floats high on the accessed lanes
          rdata_q <= cfg_we_o ? '0
                   : ((cfg_present_i ? cfg_rdata_i : '1) & lane_mask(cfg_be_o));
        end
        ST_ACK: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign cfg_req_o  = (state_q == ST_CFG);
  assign io_ack_o   = (state_q == ST_ACK);
  assign io_rdata_o = rdata_q;
endmodule

// File: rtl/cfg2_window_decoder.sv
module cfg2_window_decoder
  import cfg2_pkg::*;
#(
  parameter int unsigned IO_AW    = 16,
  parameter logic [15:0] WIN_BASE = 16'hC000,
  parameter logic [15:0] EN_PORT  = 16'hCF8,
  parameter logic [15:0] FWD_PORT = 16'hCFA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [1:0]       io_size_i,
  input  logic [31:0]      io_wdata_i,
  output logic             io_claim_o,
  output logic             io_ack_o,
  output logic [31:0]      io_rdata_o,
  output logic             cfg_req_o,
  output logic             cfg_we_o,
  output logic [7:0]       cfg_bus_o,
  output logic [3:0]       cfg_dev_o,
  output logic [2:0]       cfg_func_o,
  output logic [5:0]       cfg_dword_o,
  output logic [3:0]       cfg_be_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic             cfg_ack_i,
  input  logic             cfg_present_i,
  input  logic [31:0]      cfg_rdata_i
);
  logic [NL-1:0] be;
  logic hit_reg, hit_win, idle, active;
  logic [7:0] en_q, fwd_q;
  logic [2:0] func;
  logic [DW-1:0] reg_rdata;

  cfg2_addr_decode #(
    .IO_AW(IO_AW), .WIN_BASE(WIN_BASE), .EN_PORT(EN_PORT), .FWD_PORT(FWD_PORT)
  ) u_dec (
    .req_i(io_req_i), .idle_i(idle), .active_i(active), .addr_i(io_addr_i),
    .size_i(io_size_i), .be_o(be), .hit_reg_o(hit_reg), .hit_win_o(hit_win),
    .claim_o(io_claim_o)
  );

  cfg2_ctrl_regs #(.EN_PORT(EN_PORT), .FWD_PORT(FWD_PORT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(io_claim_o && hit_reg && io_we_i), .be_i(be), .wdata_i(io_wdata_i),
    .en_q_o(en_q), .fwd_q_o(fwd_q), .active_o(active), .func_o(func),
    .rdata_o(reg_rdata)
  );

  cfg2_xact_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .claim_i(io_claim_o), .hit_reg_i(hit_reg),
    .we_i(io_we_i), .win_off_i(io_addr_i[11:0]), .be_i(be), .wdata_i(io_wdata_i),
    .bus_i(fwd_q), .func_i(func), .reg_rdata_i(reg_rdata), .idle_o(idle),
    .io_ack_o(io_ack_o), .io_rdata_o(io_rdata_o), .cfg_req_o(cfg_req_o),
    .cfg_we_o(cfg_we_o), .cfg_bus_o(cfg_bus_o), .cfg_dev_o(cfg_dev_o),
    .cfg_func_o(cfg_func_o), .cfg_dword_o(cfg_dword_o), .cfg_be_o(cfg_be_o),
    .cfg_wdata_o(cfg_wdata_o), .cfg_ack_i(cfg_ack_i),
    .cfg_present_i(cfg_present_i), .cfg_rdata_i(cfg_rdata_i)
  );
endmodule

// File: rtl/cfg2_window_decoder_chk.sv
module cfg2_window_decoder_chk #(
  parameter int unsigned IO_AW    = 16,
  parameter logic [15:0] WIN_BASE = 16'hC000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_claim_o,
  input logic             io_ack_o,
  input logic [IO_AW-1:0] io_addr_i,
  input logic             cfg_req_o,
  input logic             cfg_ack_i,
  input logic [7:0]       cfg_bus_o,
  input logic [3:0]       cfg_dev_o,
  input logic [5:0]       cfg_dword_o,
  input logic [3:0]       cfg_be_o,
  input logic [7:0]       en_q
);
  localparam logic [IO_AW-1:0] WIN_A = IO_AW'(WIN_BASE);

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o); // R10

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_bus_o) && $stable(cfg_dev_o)
      && $stable(cfg_dword_o) && $stable(cfg_be_o)); // R8

  AST_ACK_AFTER_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i |=> io_ack_o && !cfg_req_o); // R8

  AST_WIN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_claim_o && (io_addr_i[IO_AW-1:12] == WIN_A[IO_AW-1:12]) |-> en_q[7:4] == 4'hF); // R5

  AST_BE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> ($countones(cfg_be_o) == 1) || cfg_be_o == 4'b0011
      || cfg_be_o == 4'b1100 || cfg_be_o == 4'b1111); // R7

  AST_BUSY_NOCLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o || io_ack_o) |-> !io_claim_o); // R11
endmodule

bind cfg2_window_decoder cfg2_window_decoder_chk #(.IO_AW(IO_AW), .WIN_BASE(WIN_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_claim_o(io_claim_o), .io_ack_o(io_ack_o),
  .io_addr_i(io_addr_i), .cfg_req_o(cfg_req_o), .cfg_ack_i(cfg_ack_i),
  .cfg_bus_o(cfg_bus_o), .cfg_dev_o(cfg_dev_o), .cfg_dword_o(cfg_dword_o),
  .cfg_be_o(cfg_be_o), .en_q(en_q)
);

// File: tb/cfg2_window_decoder_tb.sv
`timescale 1ns/1ps
module cfg2_window_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [1:0] io_size = '0;
  logic [31:0] io_wdata = '0;
  logic io_claim, io_ack;
  logic [31:0] io_rdata;
  logic cfg_req, cfg_we;
  logic [7:0] cfg_bus;
  logic [3:0] cfg_dev;
  logic [2:0] cfg_func;
  logic [5:0] cfg_dword;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic cfg_ack = 0, cfg_present = 0;
  logic [31:0] cfg_rdata = '0;

  int n_tests = 0, n_fail = 0;
  logic done = 0;

  always #2 clk = ~clk;

  cfg2_window_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_req_i(io_req), .io_we_i(io_we),
    .io_addr_i(io_addr), .io_size_i(io_size), .io_wdata_i(io_wdata),
    .io_claim_o(io_claim), .io_ack_o(io_ack), .io_rdata_o(io_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev),
    .cfg_func_o(cfg_func), .cfg_dword_o(cfg_dword), .cfg_be_o(cfg_be),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_present_i(cfg_present),
    .cfg_rdata_i(cfg_rdata)
  );

  // captured outcome of the last io_op
  logic c_claim, c_cfg, c_ack, c_we;
  logic [31:0] c_rdata, c_wdata;
  logic [7:0] c_bus;
  logic [3:0] c_dev, c_be;
  logic [2:0] c_func;
  logic [5:0] c_dword;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic io_op(input logic we, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic present,
                       input logic [31:0] trd, input int lat);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
    #0.5 c_claim = io_claim;
    @(negedge clk);
    io_req = 0;
    c_cfg = 0; c_ack = 0; c_rdata = '0;
    if (!c_claim) begin
      for (int i = 0; i < 3; i++) begin
        if (io_ack || cfg_req) c_ack = 1;
        @(negedge clk);
      end
      return;
    end
    if (cfg_req) begin
      c_cfg = 1; c_we = cfg_we; c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func;
      c_dword = cfg_dword; c_be = cfg_be; c_wdata = cfg_wdata;
      for (int i = 0; i < lat; i++) @(negedge clk);
      cfg_ack = 1; cfg_present = present; cfg_rdata = trd;
      @(negedge clk);
      cfg_ack = 0; cfg_present = 0; cfg_rdata = '0;
    end
    c_ack = io_ack; c_rdata = io_rdata;
    @(negedge clk);
    chk(!io_ack, "R10 ack pulse", 32'(io_ack), 0);
  endtask

  task automatic t_reset();
    chk(!io_ack && !cfg_req, "R1 idle outputs", {30'b0, io_ack, cfg_req}, 0);
    io_op(0, 16'hCF8, 2, 0, 0, 0, 0);
    chk(c_ack && c_rdata == 0, "R1 ctrl ports zero", c_rdata, 0);
    io_op(0, 16'hC000, 2, 0, 1, 0, 0);
    chk(!c_claim && !c_ack, "R1 window closed", 32'(c_claim), 0);
  endtask

  task automatic t_regs();
    io_op(1, 16'hCF8, 0, 32'h000000F5, 0, 0, 0);
    chk(c_ack && c_rdata == 0, "R10 reg write ack", c_rdata, 0);
    io_op(0, 16'hCF8, 0, 0, 0, 0, 0);
    chk(c_rdata == 32'h000000F5, "R2 enable readback", c_rdata, 32'h000000F5);
    io_op(1, 16'hCFA, 0, 32'h003C0000, 0, 0, 0);
    io_op(0, 16'hCFA, 0, 0, 0, 0, 0);
    chk(c_rdata == 32'h003C0000, "R3 forward readback", c_rdata, 32'h003C0000);
    io_op(0, 16'hCF8, 2, 0, 0, 0, 0);
    chk(c_rdata == 32'h003C00F5, "R2 dword readback", c_rdata, 32'h003C00F5);
    io_op(1, 16'hCF8, 0, 0, 0, 0, 0);
    io_op(1, 16'hCFA, 0, 0, 0, 0, 0);
    io_op(0, 16'hCF8, 0, 0, 0, 0, 0);
    chk(c_rdata == 0, "R3 enable zero", c_rdata, 0);
    io_op(0, 16'hCFA, 0, 0, 0, 0, 0);
    chk(c_rdata == 0, "R3 forward zero", c_rdata, 0);
  endtask

  task automatic t_enable();
    io_op(1, 16'hCF8, 0, 32'hE2, 0, 0, 0);
    io_op(0, 16'hC100, 2, 0, 1, 0, 0);
    chk(!c_claim, "R4 nibble E closed", 32'(c_claim), 0);
    io_op(1, 16'hCF8, 0, 32'hF0, 0, 0, 0);
    io_op(0, 16'hC100, 2, 0, 1, 32'h11, 0);
    chk(c_claim && c_cfg && c_ack, "R4 nibble F open", 32'(c_claim), 1);
    io_op(1, 16'hCF8, 0, 32'h00, 0, 0, 0);
    io_op(0, 16'hC100, 2, 0, 1, 0, 0);
    chk(!c_claim && !c_ack, "R4 zero closes", 32'(c_claim), 0);
  endtask

  task automatic t_route();
    io_op(1, 16'hCF8, 0, 32'hF6, 0, 0, 0);
    io_op(1, 16'hCFA, 0, 32'h005A0000, 0, 0, 0);
    io_op(0, 16'hC7A4, 1, 0, 1, 32'h12345678, 0);
    chk(c_cfg && c_bus == 8'h5A && c_func == 3, "R6 bus/func", {c_bus, 21'b0, c_func}, {8'h5A, 21'b0, 3'd3});
    chk(c_dev == 7 && c_dword == 6'h29 && !c_we, "R6 dev/dword", {c_dev, 6'b0, c_dword}, {4'd7, 6'b0, 6'h29});
    chk(c_rdata == 32'h00005678, "R9 present word", c_rdata, 32'h00005678);
    io_op(1, 16'hCF10, 2, 32'hDEADBEEF, 1, 0, 0);
    chk(c_we && c_dev == 15 && c_dword == 4 && c_wdata == 32'hDEADBEEF, "R6 write fields",
        c_wdata, 32'hDEADBEEF);
    chk(c_ack && c_rdata == 0, "R9 write data zero", c_rdata, 0);
    io_op(1, 16'hC302, 0, 32'hAABBCCDD, 1, 0, 0);
    chk(c_wdata == 32'h00BB0000 && c_be == 4'b0100, "R6 write lane mask", c_wdata, 32'h00BB0000);
  endtask

  task automatic t_be();
    io_op(0, 16'hC003, 0, 0, 1, '1, 0);
    chk(c_be == 4'b1000, "R7 byte a=3", 32'(c_be), 32'h8);
    io_op(0, 16'hC001, 0, 0, 1, '1, 0);
    chk(c_be == 4'b0010, "R7 byte a=1", 32'(c_be), 32'h2);
    io_op(0, 16'hC002, 1, 0, 1, '1, 0);
    chk(c_be == 4'b1100, "R7 word high", 32'(c_be), 32'hC);
    io_op(0, 16'hC001, 2, 0, 1, '1, 0);
    chk(c_be == 4'b1111, "R7 dword", 32'(c_be), 32'hF);
  endtask

  task automatic t_absent();
    io_op(0, 16'hC305, 0, 0, 0, 32'h12345678, 0);
    chk(c_rdata == 32'h0000FF00, "R9 absent byte", c_rdata, 32'h0000FF00);
    io_op(0, 16'hC300, 2, 0, 0, 32'h0, 0);
    chk(c_rdata == 32'hFFFFFFFF, "R9 absent dword", c_rdata, 32'hFFFFFFFF);
  endtask

  task automatic t_latency();
    io_op(0, 16'hC408, 2, 0, 1, 32'hCAFEF00D, 3);
    chk(c_ack && c_rdata == 32'hCAFEF00D, "R8 late target ack", c_rdata, 32'hCAFEF00D);
  endtask

  task automatic t_outside();
    io_op(0, 16'hD000, 2, 0, 1, 0, 0);
    chk(!c_claim && !c_ack, "R5 above window", 32'(c_claim), 0);
    io_op(0, 16'hBFFF, 0, 0, 1, 0, 0);
    chk(!c_claim && !c_ack, "R5 below window", 32'(c_claim), 0);
    io_op(0, 16'hCFC, 2, 0, 1, 0, 0);
    chk(!c_claim && !c_ack, "R5 next dword port", 32'(c_claim), 0);
  endtask

  task automatic t_busy();
    logic cl;
    @(negedge clk);
    io_req = 1; io_we = 0; io_addr = 16'hC200; io_size = 2;
    @(negedge clk);
    io_we = 1; io_addr = 16'hCF8; io_size = 0; io_wdata = 0;
    #0.5 cl = io_claim;
    chk(!cl, "R11 claim while busy", 32'(cl), 0);
    @(negedge clk);
    io_req = 0; cfg_ack = 1; cfg_present = 1;
    @(negedge clk);
    cfg_ack = 0;
    @(negedge clk);
    io_op(0, 16'hCF8, 0, 0, 0, 0, 0);
    chk(c_rdata == 32'hF6, "R11 enable unchanged", c_rdata, 32'hF6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_route();
    t_be();
    t_absent();
    t_latency();
    t_outside();
    t_busy();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule